// File: doc/BRIEF.md
# Dual-Channel Serial Converter Output Model

This block stands in for the digital side of a two-channel, 14-bit sampling converter, so that a host read controller can be exercised against realistic serial timing. A falling edge on the conversion-start input captures one word from each of two parallel data buses and raises busy for a fixed number of system clock cycles. The host then lowers chip select and toggles its serial clock. The two captured words are shifted out, most significant bit first, on two data outputs. Each data output has its own enable, and a low enable stands for high impedance.

If chip select stays low for more than one word, the selected output continues with the other channel's word. A host can then collect both results from one pin with 28 clocks. A configuration input picks which pin carries this chained stream. The other pin drives zeros after its own word. All host signals are sampled on the rising edge of the system clock, and edges are found by comparing each sample with the one before.

Top module: `adc_serial_model`

## Requirements
- R1: Once reset is released, busy is 0 and both output enables are 0 until the host acts.
- R2: A falling conversion-start sample while busy is 0 captures `data_a` and `data_b` and makes busy 1 for exactly CONV_CYCLES cycles, starting one cycle after that sample. A conversion-start fall while busy is 1 is ignored: the captured words do not change.
- R3: One cycle after chip select is first sampled low, both enables are 1. `dout_a` shows bit 13 of the captured A word and `dout_b` shows bit 13 of the captured B word.
- R4: Each counted serial-clock falling edge (high sample followed by low sample) while chip select stays low moves both outputs one bit lower. After n counted edges (n < 14), each output shows bit 13-n of its own word.
- R5: With `chain_sel` = 0, `dout_a` shows B word bit 27-n after n counted edges, for 14 <= n < 28. With `chain_sel` = 1, `dout_b` shows A word bit 27-n over the same range.
- R6: The pin that is not chained drives 0 once n >= 14. The chained pin drives 0 once n >= 28. Both pins hold 0 until chip select rises.
- R7: One cycle after chip select is sampled high, both enables are 0. A later chip-select fall restarts at bit 13, even if the previous transfer was cut short.
- R8: A serial-clock fall found in the same sample as the chip-select fall is not counted, so the outputs still show bit 13.
- R9: Chip select may be lowered while busy is 1. When busy falls, both outputs already show bit 13 of the words captured at the start of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_n | input | 1 | Conversion start; a falling edge starts a conversion |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Host serial clock; falling edges shift the outputs |
| chain_sel | input | 1 | Chained-stream pin: 0 = `dout_a`, 1 = `dout_b` |
| data_a | input | WORD_W | Channel A word, captured at conversion start |
| data_b | input | WORD_W | Channel B word, captured at conversion start |
| busy | output | 1 | High while a conversion is in progress |
| dout_a | output | 1 | Serial data, line A |
| doe_a | output | 1 | Drive enable for line A (0 = high impedance) |
| dout_b | output | 1 | Serial data, line B |
| doe_b | output | 1 | Drive enable for line B (0 = high impedance) |

## Verification
A wrong bit index shows up on the data pins at the first serial-clock fall after the fault. An extra or missed shift shifts every later bit of the stream, so the error is caught within one clock edge of its cause. A wrong busy counter changes the busy width seen on the pin in the same conversion. Stale enable state is visible one cycle after chip select moves. Corrupted captured words appear as soon as the first affected bit is shifted out, which for the MSB is the cycle after chip select falls.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
   // which output pin continues with the other channel's word
   typedef enum logic {
      CHAIN_ON_A = 1'b0,
      CHAIN_ON_B = 1'b1
   } chain_pin_e;

   function automatic int unsigned width_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= sig_in;
   end

   assign fall = prev_q & ~sig_in;
endmodule

// File: rtl/adc_emu_timer.sv
module adc_emu_timer #(
   parameter int unsigned CONV_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic start,
   output logic busy
);
   localparam int unsigned CW = adc_emu_pkg::width_for(CONV_CYCLES);

   logic [CW-1:0] remain_q;

   assign start = trig & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         remain_q <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         remain_q <= CW'(CONV_CYCLES - 1);
      end else if (busy) begin
         if (remain_q == '0) busy <= 1'b0;
         else                remain_q <= remain_q - 1'b1;
      end
   end
endmodule

// File: rtl/adc_emu_lane.sv
module adc_emu_lane #(
   parameter int unsigned WORD_W = 14,
   parameter int unsigned IDX_W  = 5
) (
   input  logic [WORD_W-1:0] own_word,
   input  logic [WORD_W-1:0] other_word,
   input  logic              chain_en,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic              bit_out
);
   logic [2*WORD_W-1:0] stream;
   logic [2*WORD_W-1:0] shifted;

   always_comb begin
      stream  = chain_en ? {own_word, other_word} : {own_word, {WORD_W{1'b0}}};
      shifted = stream << bit_idx;
      bit_out = shifted[2*WORD_W-1];
   end
endmodule

// File: rtl/adc_serial_model.sv
module adc_serial_model #(
   parameter int unsigned WORD_W      = 14,
   parameter int unsigned CONV_CYCLES = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              chain_sel,
   input  logic [WORD_W-1:0] data_a,
   input  logic [WORD_W-1:0] data_b,
   output logic              busy,
   output logic              dout_a,
   output logic              doe_a,
   output logic              dout_b,
   output logic              doe_b
);
   import adc_emu_pkg::*;

   localparam int unsigned BITS_TOTAL = 2 * WORD_W;
   localparam int unsigned IDX_W      = width_for(BITS_TOTAL);
   localparam int unsigned N_LANES    = 2;

   if (WORD_W < 2) begin : g_bad_width
      $error("adc_serial_model: WORD_W must be at least 2");
   end
   if (CONV_CYCLES < 1) begin : g_bad_conv
      $error("adc_serial_model: CONV_CYCLES must be at least 1");
   end

   // edge finders: index 0 = chip select, 1 = serial clock, 2 = conversion start
   logic [2:0] raw_in;
   logic [2:0] fell;
   assign raw_in = {conv_n, sclk, cs_n};

   for (genvar e = 0; e < 3; e++) begin : g_edge
      adc_emu_edge #(.IDLE_VAL(1'b1)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .sig_in (raw_in[e]),
         .fall   (fell[e])
      );
   end

   logic cs_fall, sclk_fall, conv_fall, conv_start;
   assign cs_fall   = fell[0];
   assign sclk_fall = fell[1];
   assign conv_fall = fell[2];

   adc_emu_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (conv_fall),
      .start (conv_start),
      .busy  (busy)
   );

   logic [WORD_W-1:0] word_a, word_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_a <= '0;
         word_b <= '0;
      end else if (conv_start) begin
         word_a <= data_a;
         word_b <= data_b;
      end
   end

   // read sequencer: chip-select fall wins over a coincident serial-clock fall
   logic             drive_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         idx_q   <= '0;
      end else if (cs_n) begin
         drive_q <= 1'b0;
         idx_q   <= '0;
      end else if (cs_fall) begin
         drive_q <= 1'b1;
         idx_q   <= '0;
      end else if (sclk_fall && idx_q != IDX_W'(BITS_TOTAL)) begin
         idx_q   <= idx_q + 1'b1;
      end
   end

   logic [N_LANES-1:0][WORD_W-1:0] words;
   logic [N_LANES-1:0]             lane_bit;
   chain_pin_e                     chain_pin;

   assign words     = {word_b, word_a};
   assign chain_pin = chain_pin_e'(chain_sel);

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      adc_emu_lane #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_lane (
         .own_word   (words[l]),
         .other_word (words[N_LANES-1-l]),
         .chain_en   (chain_pin == ((l == 0) ? CHAIN_ON_A : CHAIN_ON_B)),
         .bit_idx    (idx_q),
         .bit_out    (lane_bit[l])
      );
   end

   assign dout_a = drive_q & lane_bit[0];
   assign dout_b = drive_q & lane_bit[1];
   assign doe_a  = drive_q;
   assign doe_b  = drive_q;
endmodule

module adc_emu_chk #(
   parameter int unsigned WORD_W      = 14,
   parameter int unsigned CONV_CYCLES = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_n,
   input logic              cs_n,
   input logic              sclk,
   input logic              chain_sel,
   input logic              busy,
   input logic              dout_a,
   input logic              doe_a,
   input logic              dout_b,
   input logic              doe_b,
   input logic [WORD_W-1:0] word_a,
   input logic [WORD_W-1:0] word_b
);
   localparam int unsigned RW = adc_emu_pkg::width_for(CONV_CYCLES + 1);

   logic [RW-1:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n)                          busy_run <= '0;
      else if (!busy)                      busy_run <= '0;
      else if (busy_run != {RW{1'b1}})     busy_run <= busy_run + 1'b1;
   end

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(conv_n) && !busy) |=> busy);

   // R2
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= RW'(CONV_CYCLES));

   // R7
   idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!doe_a && !doe_b));

   // R3
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> (doe_a && doe_b && dout_a == word_a[WORD_W-1] && dout_b == word_b[WORD_W-1]));

   // R4
   no_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$fell(cs_n) && !$fell(sclk) && !$fell(conv_n) && $stable(chain_sel))
      |=> ($stable(dout_a) && $stable(dout_b)));
endmodule

bind adc_serial_model adc_emu_chk #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .conv_n    (conv_n),
   .cs_n      (cs_n),
   .sclk      (sclk),
   .chain_sel (chain_sel),
   .busy      (busy),
   .dout_a    (dout_a),
   .doe_a     (doe_a),
   .dout_b    (dout_b),
   .doe_b     (doe_b),
   .word_a    (word_a),
   .word_b    (word_b)
);

// File: tb/test_adc_serial_model.sv
module test_adc_serial_model;
   localparam int W  = 14;
   localparam int CC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_n = 1'b1, cs_n = 1'b1, sclk = 1'b1, chain_sel = 1'b0;
   logic [W-1:0] data_a = '0, data_b = '0;
   logic busy, dout_a, doe_a, dout_b, doe_b;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_serial_model #(.WORD_W(W), .CONV_CYCLES(CC)) i_adc_serial_model (
      .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .sclk(sclk),
      .chain_sel(chain_sel), .data_a(data_a), .data_b(data_b), .busy(busy),
      .dout_a(dout_a), .doe_a(doe_a), .dout_b(dout_b), .doe_b(doe_b));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected serial bit after n counted edges
   function automatic logic exp_bit(input logic [W-1:0] own, input logic [W-1:0] other,
                                    input bit chained, input int n);
      if (n < W) return own[W-1-n];
      if (chained && n < 2*W) return other[2*W-1-n];
      return 1'b0;
   endfunction

   function automatic string tag_for(input bit chained, input int n);
      if (n < W) return "R4";
      if (chained && n < 2*W) return "R5";
      return "R6";
   endfunction

   task automatic convert(input logic [W-1:0] a, input logic [W-1:0] b);
      int cnt;
      data_a = a; data_b = b; conv_n = 1'b0;
      tick();
      conv_n = 1'b1;
      chk(busy === 1'b1, "R2 busy rise", busy, 1);
      cnt = 1;
      while (cnt < 1000) begin
         tick();
         if (busy !== 1'b1) break;
         cnt++;
      end
      chk(cnt == CC, "R2 busy width", cnt, CC);
   endtask

   task automatic read(input logic [W-1:0] a, input logic [W-1:0] b, input bit chain,
                       input int nclk, input bit coincide);
      chain_sel = chain; cs_n = 1'b0;
      if (coincide) sclk = 1'b0;
      tick();
      chk(doe_a === 1'b1 && doe_b === 1'b1, "R3 enables", {doe_a, doe_b}, 2'b11);
      chk(dout_a === a[W-1] && dout_b === b[W-1], coincide ? "R8 msb" : "R3 msb",
          {dout_a, dout_b}, {a[W-1], b[W-1]});
      for (int n = 1; n <= nclk; n++) begin
         sclk = 1'b1; tick();
         sclk = 1'b0; tick();
         chk(dout_a === exp_bit(a, b, chain == 1'b0, n), tag_for(chain == 1'b0, n),
             dout_a, exp_bit(a, b, chain == 1'b0, n));
         chk(dout_b === exp_bit(b, a, chain == 1'b1, n), tag_for(chain == 1'b1, n),
             dout_b, exp_bit(b, a, chain == 1'b1, n));
      end
      cs_n = 1'b1; sclk = 1'b1;
      tick();
      chk(doe_a === 1'b0 && doe_b === 1'b0, "R7 release", {doe_a, doe_b}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] a, b, a2;
      void'($urandom(32'h5eed_1234));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1
      chk(busy === 1'b0 && doe_a === 1'b0 && doe_b === 1'b0, "R1 reset", {busy, doe_a, doe_b}, 0);

      // directed: full chained reads on both pins
      convert(14'h2A5C, 14'h1337);
      read(14'h2A5C, 14'h1337, 1'b0, 31, 1'b0);
      read(14'h2A5C, 14'h1337, 1'b1, 31, 1'b0);
      // R8: serial-clock fall together with chip-select fall
      read(14'h2A5C, 14'h1337, 1'b0, 3, 1'b1);
      // R7: aborted transfer then restart at MSB
      read(14'h2A5C, 14'h1337, 1'b1, 5, 1'b0);
      read(14'h2A5C, 14'h1337, 1'b1, 2, 1'b0);

      // R9 and R2 ignore: read starts during busy, second start is ignored
      a = 14'h3FFF ^ 14'h0155; b = 14'h2001; a2 = ~a;
      data_a = a; data_b = b; conv_n = 1'b0; tick();
      conv_n = 1'b1; cs_n = 1'b0; tick();
      data_a = a2; data_b = ~b; conv_n = 1'b0; tick();
      conv_n = 1'b1;
      for (int g = 0; g < 1000 && busy === 1'b1; g++) tick();
      chk(dout_a === a[W-1] && dout_b === b[W-1] && doe_a === 1'b1, "R9 msb at busy fall",
          {doe_a, dout_a, dout_b}, {1'b1, a[W-1], b[W-1]});
      for (int n = 1; n < W; n++) begin
         sclk = 1'b0; tick();
         chk(dout_a === a[W-1-n], "R2 ignored start", dout_a, a[W-1-n]);
         sclk = 1'b1; tick();
      end
      cs_n = 1'b1; tick();

      // constrained random transactions
      for (int t = 0; t < 30; t++) begin
         a = W'($urandom); b = W'($urandom);
         convert(a, b);
         read(a, b, 1'(($urandom) & 1), $urandom_range(0, 31), ($urandom_range(0, 3) == 0));
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule